// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer in front of an external successive-approximation converter. Software writes one control word that picks a channel code, a sequence length of four or eight conversions, and two mode bits. One mode bit selects between repeating a single channel and walking a group of consecutive channels. The other selects between running the sequence once and running it continuously. Every write to the control word throws away whatever sequence is in progress and starts a fresh one.

Each conversion goes to the converter as a one-cycle start pulse that carries a channel number and a small transaction tag. The converter answers with a done strobe that echoes the tag, together with a 10-bit result. Conversion N of a sequence lands in result slot N, and the matching per-slot complete flag sets. A sequence-complete flag sets when the last result of a sequence is stored. A done strobe whose tag belongs to an aborted sequence is discarded.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Read address 0 returns the control word in bits 6..0, with bits 15..7 reading zero. The fields are channel code in 3..0, length bit in 4, multichannel bit in 5 and scan bit in 6. A write to any address other than 0 leaves the control word unchanged and starts nothing.
- R2: A write to address 0 makes `conv_start` high in the next cycle. That pulse carries a tag different from the tag in force before the write.
- R3: A write to address 0 while a sequence runs aborts it. In the next cycle the status reads zero (all slot flags and the sequence flag clear).
- R4: With the scan bit at 0, exactly one sequence runs and no further start pulse follows. With it at 1, sequences repeat without a new write. Each start pulse lasts one cycle.
- R5: With the multichannel bit at 0, every conversion uses the channel code unchanged.
- R6: With the multichannel bit at 1, conversion i uses B+i. B is the channel code with its low 2 bits cleared (length bit 0) or its low 3 bits cleared (length bit 1).
- R7: With the length bit at 0 a sequence has four conversions. With it at 1 a sequence has eight.
- R8: The result of conversion i of a sequence is readable at address 8+i in bits 9..0. Status bit i (address 1) sets in the cycle after that done strobe is accepted.
- R9: Status bit 8 sets together with the flag of the last conversion of a sequence. In continuous mode it stays set until the next control write.
- R10: A done strobe is accepted only while a conversion is outstanding and its tag equals the tag of the current sequence. Any other done strobe changes no flag and no slot.
- R11: After reset no conversion is started, and every readable address returns zero.
- R12: When a control write and an accepted-looking done strobe fall in the same cycle, the write wins. The flags read zero afterwards and the result slot keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Write address (0 = control word) |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 4 | Read address (0 control, 1 status, 8..15 result slots) |
| bus_rdata | output | 16 | Read data, combinational from bus_raddr |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the requested conversion |
| conv_tag | output | 2 | Transaction tag of the current sequence |
| conv_done | input | 1 | Conversion finished strobe |
| conv_done_tag | input | 2 | Tag echoed with the done strobe |
| conv_result | input | 10 | Conversion result |

## Verification
A control write and a converter done strobe can land in the same clock cycle. The write must then win: the flags clear and the slot is not updated. The bench provokes this by waiting until the converter stub has just raised a done strobe carrying the live tag, then issuing a control write before the next clock edge. It judges the outcome by reading status and slot 0 in the following cycle, comparing against the value slot 0 held just before the write. A second overlap is a stale done strobe arriving while the new sequence is waiting on its own conversion. The bench forces this by aborting with a long converter latency, and the per-cycle reference model confirms that the stale result never reaches a slot.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes a 4-bit channel code and a 7-bit control word packed as
// scan(6) multichannel(5) length(4) code(3..0).
package adc_seq_pkg;
    localparam int CHAN_W = 4;

    typedef struct packed {
        logic              scan;
        logic              mult;
        logic              len8;
        logic [CHAN_W-1:0] code;
    } seq_cfg_t;

    localparam int CFG_W = $bits(seq_cfg_t);

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_t;
endpackage

// File: rtl/adc_cfg_reg.sv
// Control word register. Captures the mode fields on a write to the
// control address and advances the sequence tag so that any conversion
// still in flight is recognised as stale. Assumes one write per cycle.
module adc_cfg_reg
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    output seq_cfg_t          cfg,
    output logic              restart,
    output logic [TAG_W-1:0]  epoch
);
    // Decode a control-word write.
    assign restart = bus_wr && (bus_waddr == CFG_ADDR);

    // Hold the control fields and the sequence tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            epoch <= '0;
        end else if (restart) begin
            cfg   <= seq_cfg_t'(bus_wdata[CFG_W-1:0]);
            epoch <= epoch + TAG_W'(1);
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencer: issues one start pulse per conversion, waits for the
// matching done strobe, steps the slot index and channel, and decides
// whether to stop or repeat. Assumes the converter echoes the tag.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int TAG_W = 2,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  seq_cfg_t          cfg,
    input  logic [TAG_W-1:0]  epoch,
    input  logic              conv_done,
    input  logic [TAG_W-1:0]  conv_done_tag,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [TAG_W-1:0]  conv_tag,
    output logic              accept,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              seq_last
);
    localparam logic [CHAN_W-1:0] MASK_LONG  = ~CHAN_W'(SLOTS - 1);
    localparam logic [CHAN_W-1:0] MASK_SHORT = ~CHAN_W'(SLOTS / 2 - 1);
    localparam logic [IDX_W-1:0]  LAST_LONG  = IDX_W'(SLOTS - 1);
    localparam logic [IDX_W-1:0]  LAST_SHORT = IDX_W'(SLOTS / 2 - 1);

    sq_state_t         state;
    logic [IDX_W-1:0]  idx;
    logic [CHAN_W-1:0] group_base;

    // Current slot, end-of-sequence and acceptance of a done strobe.
    assign slot_idx = idx;
    assign seq_last = (idx == (cfg.len8 ? LAST_LONG : LAST_SHORT));
    assign accept   = (state == SQ_WAIT) && conv_done &&
                      (conv_done_tag == epoch) && !restart;

    // Channel for the conversion being issued.
    always_comb begin
        group_base = cfg.code & (cfg.len8 ? MASK_LONG : MASK_SHORT);
        conv_chan  = cfg.mult ? (group_base + CHAN_W'(idx)) : cfg.code;
    end

    assign conv_start = (state == SQ_ISSUE);
    assign conv_tag   = epoch;

    // Sequence state and slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx   <= '0;
        end else if (restart) begin
            state <= SQ_ISSUE;
            idx   <= '0;
        end else begin
            case (state)
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (accept) begin
                        if (seq_last) begin
                            idx   <= '0;
                            state <= cfg.scan ? SQ_ISSUE : SQ_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Result slots with per-slot complete flags and the sequence-complete
// flag. Assumes accept is never high in a cycle where clear is high.
module adc_result_bank #(
    parameter int SLOTS = 8,
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             seq_last,
    input  logic [RES_W-1:0] result,
    output logic [RES_W-1:0] slot_data [SLOTS],
    output logic [SLOTS-1:0] flags,
    output logic             seq_done
);
    // One storage register per slot.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_data[i] <= '0;
            else if (accept && (slot_idx == IDX_W'(i)))
                slot_data[i] <= result;
        end
    end

    // Completion flags: cleared by a restart, set by accepted results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            seq_done <= 1'b0;
        end else if (clear) begin
            flags    <= '0;
            seq_done <= 1'b0;
        end else if (accept) begin
            flags[slot_idx] <= 1'b1;
            if (seq_last)
                seq_done <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion sequencer. Ties the control register, the
// sequencer and the result bank together and decodes the read port.
// Assumes a single-cycle register port with combinational read data.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int RES_W  = 10,
    parameter int SLOTS  = 8,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [TAG_W-1:0]  conv_tag,
    input  logic              conv_done,
    input  logic [TAG_W-1:0]  conv_done_tag,
    input  logic [RES_W-1:0]  conv_result
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RES_BASE  = ADDR_W'((2 ** ADDR_W) - SLOTS);

    seq_cfg_t         cfg;
    logic             restart;
    logic [TAG_W-1:0] epoch;
    logic             accept;
    logic [IDX_W-1:0] slot_idx;
    logic             seq_last;
    logic [RES_W-1:0] slot_data [SLOTS];
    logic [SLOTS-1:0] flags;
    logic             seq_done;
    logic [IDX_W-1:0] rd_slot;

    adc_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .cfg(cfg), .restart(restart), .epoch(epoch)
    );

    adc_seq_fsm #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cfg(cfg),
        .epoch(epoch), .conv_done(conv_done), .conv_done_tag(conv_done_tag),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_tag(conv_tag),
        .accept(accept), .slot_idx(slot_idx), .seq_last(seq_last)
    );

    adc_result_bank #(.SLOTS(SLOTS), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear(restart), .accept(accept),
        .slot_idx(slot_idx), .seq_last(seq_last), .result(conv_result),
        .slot_data(slot_data), .flags(flags), .seq_done(seq_done)
    );

    assign rd_slot = IDX_W'(bus_raddr - RES_BASE);

    // Read decode: control word, status, or one result slot.
    always_comb begin
        bus_rdata = '0;
        if (bus_raddr == CFG_ADDR)
            bus_rdata[CFG_W-1:0] = cfg;
        else if (bus_raddr == STAT_ADDR)
            bus_rdata[SLOTS:0] = {seq_done, flags};
        else if (bus_raddr >= RES_BASE)
            bus_rdata[RES_W-1:0] = slot_data[rd_slot];
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Checker for the conversion sequencer, bound into the top module.
// Observes the ports plus the restart, tag, configuration and flag
// signals that separate submodules drive.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int TAG_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input seq_cfg_t          cfg,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [TAG_W-1:0]  conv_tag,
    input logic              conv_done,
    input logic [TAG_W-1:0]  conv_done_tag,
    input logic [SLOTS-1:0]  flags,
    input logic              seq_done
);
    a_r2_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> conv_start);

    a_r2_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (conv_tag != $past(conv_tag)));

    a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((flags == '0) && !seq_done));

    a_r4_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !restart) |=> !conv_start);

    a_r6_chan_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && cfg.mult && !cfg.len8) |->
            (conv_chan[CHAN_W-1:2] == cfg.code[CHAN_W-1:2]));

    a_r8_one_flag_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($countones(flags & ~$past(flags)) <= 1));

    a_r9_done_holds_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && cfg.scan && !restart) |=> seq_done);

    a_r10_stale_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && conv_done && (conv_done_tag != conv_tag)) |=>
            ($stable(flags) && $stable(seq_done)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg(cfg),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_tag(conv_tag),
    .conv_done(conv_done), .conv_done_tag(conv_done_tag),
    .flags(flags), .seq_done(seq_done)
);

// File: tb/adc_seq_ctrl_test.sv
// Bench: converter stub with configurable latency, behavioural
// reference model compared every cycle, and directed scenario checks.
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [3:0]  bus_raddr = '0;
    logic [15:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_tag;
    logic        conv_done = 1'b0;
    logic [1:0]  conv_done_tag = '0;
    logic [9:0]  conv_result = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_tag(conv_tag),
        .conv_done(conv_done), .conv_done_tag(conv_done_tag),
        .conv_result(conv_result)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit run_chk = 0, rot_en = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int       m_state = 0, m_idx = 0, m_epoch = 0;
    bit [6:0] m_cfg = '0;
    bit [7:0] m_flags = '0;
    bit       m_sdone = 0;
    int       m_res [8];

    always @(posedge clk) begin
        bit w, acc;
        int mlen;
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_epoch = 0; m_cfg = '0;
            m_flags = '0; m_sdone = 0;
            for (int i = 0; i < 8; i++) m_res[i] = 0;
        end else begin
            mlen = m_cfg[4] ? 8 : 4;
            w    = bus_wr && (bus_waddr == 4'd0);
            acc  = !w && (m_state == 2) && conv_done &&
                   (int'(conv_done_tag) == (m_epoch % 4));
            if (w) begin
                m_cfg = bus_wdata[6:0]; m_epoch++; m_flags = '0;
                m_sdone = 0; m_state = 1; m_idx = 0;
            end else if (m_state == 1) begin
                m_state = 2;
            end else if (acc) begin
                m_res[m_idx]   = int'(conv_result);
                m_flags[m_idx] = 1'b1;
                if (m_idx == mlen - 1) begin
                    m_sdone = 1; m_idx = 0;
                    m_state = m_cfg[6] ? 1 : 0;
                end else begin
                    m_idx++; m_state = 1;
                end
            end
        end
    end

    function automatic int exp_chan();
        int sh;
        if (m_cfg[5]) begin
            sh = m_cfg[4] ? 3 : 2;
            return ((((int'(m_cfg[3:0])) >> sh) << sh) + m_idx) & 15;
        end
        return int'(m_cfg[3:0]);
    endfunction

    function automatic int exp_rd(input int a);
        if (a == 0) return int'(m_cfg);
        if (a == 1) return (int'(m_sdone) << 8) | int'(m_flags);
        if (a >= 8) return m_res[a-8];
        return 0;
    endfunction

    // ---------------- converter stub ----------------
    int lat = 3, nstart = 0, nres = 0, stale_cnt = 0;
    int q_due[$], q_tag[$], q_chan[$], chan_log[$];

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (rst_n && conv_start) begin
            q_due.push_back(cyc + lat);
            q_tag.push_back(int'(conv_tag));
            q_chan.push_back(int'(conv_chan));
            chan_log.push_back(int'(conv_chan));
            nstart++;
        end
        if (q_due.size() > 0 && q_due[0] <= cyc) begin
            conv_done     = 1'b1;
            conv_done_tag = 2'(q_tag[0]);
            conv_result   = 10'((q_chan[0] * 53 + nres * 29 + 7) % 1024);
            nres++;
            if (q_tag[0] != (m_epoch % 4)) stale_cnt++;
            void'(q_due.pop_front());
            void'(q_tag.pop_front());
            void'(q_chan.pop_front());
        end
    end

    // Background read-address sweep.
    always @(negedge clk) if (rot_en) bus_raddr = bus_raddr + 4'd1;

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #3;
        if (rst_n && run_chk) begin
            check(conv_start == (m_state == 1), "R2 start pulse",
                  int'(conv_start), int'(m_state == 1));
            if (m_state == 1) begin
                check(int'(conv_chan) == exp_chan(),
                      m_cfg[5] ? "R6 group channel" : "R5 fixed channel",
                      int'(conv_chan), exp_chan());
                check(int'(conv_tag) == (m_epoch % 4), "R10 tag",
                      int'(conv_tag), m_epoch % 4);
            end
            check(int'(bus_rdata) == exp_rd(int'(bus_raddr)),
                  (bus_raddr == 0) ? "R1 control readback" :
                  (bus_raddr == 1) ? "R9 status" :
                  (bus_raddr >= 8) ? "R8 result slot" : "R1 unused address",
                  int'(bus_rdata), exp_rd(int'(bus_raddr)));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rot_en = 0;
        @(negedge clk);
        bus_raddr = a;
        #4;
        v = int'(bus_rdata);
        rot_en = 1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (m_state == 0) break;
        end
    endtask

    int v, s0, r_before;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_chk = 1;

        // R11: reset state
        check(conv_start == 1'b0, "R11 no start after reset", int'(conv_start), 0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check(v == 0, "R11 zero after reset", v, 0);
        end
        rot_en = 1;

        // R1, R5, R7, R4: single channel, four conversions, run once
        s0 = nstart;
        wr(4'd0, 16'hFF85);
        rd(4'd0, v);
        check(v == 16'h0005, "R1 upper bits read zero", v, 16'h0005);
        wait_idle();
        check(nstart - s0 == 4, "R7 four conversions", nstart - s0, 4);
        rd(4'd1, v);
        check(v == 16'h010F, "R9 status after four", v, 16'h010F);
        s0 = nstart;
        repeat (20) @(negedge clk);
        check(nstart == s0, "R4 stops after one sequence", nstart - s0, 0);

        // R6, R7: group of eight from code 7
        chan_log.delete(); s0 = nstart;
        wr(4'd0, 16'h0037);
        wait_idle();
        check(nstart - s0 == 8, "R7 eight conversions", nstart - s0, 8);
        check(chan_log.size() == 8 && chan_log[0] == 0 && chan_log[7] == 7,
              "R6 group 0..7", chan_log.size() > 0 ? chan_log[0] : -1, 0);
        rd(4'd1, v);
        check(v == 16'h01FF, "R9 status after eight", v, 16'h01FF);
        rd(4'd15, v);
        check(v == m_res[7], "R8 slot 7", v, m_res[7]);

        // R6: group of four from code 14 -> 12..15
        chan_log.delete();
        wr(4'd0, 16'h002E);
        wait_idle();
        check(chan_log.size() == 4 && chan_log[0] == 12 && chan_log[3] == 15,
              "R6 group 12..15", chan_log.size() > 0 ? chan_log[0] : -1, 12);

        // R6: group of eight from code 11 -> 8..15
        chan_log.delete();
        wr(4'd0, 16'h003B);
        wait_idle();
        check(chan_log.size() == 8 && chan_log[0] == 8 && chan_log[7] == 15,
              "R6 group 8..15", chan_log.size() > 0 ? chan_log[0] : -1, 8);

        // R1: write to a non-control address has no effect
        s0 = nstart;
        wr(4'd1, 16'h0055);
        repeat (10) @(negedge clk);
        check(nstart == s0, "R1 other address starts nothing", nstart - s0, 0);
        rd(4'd0, v);
        check(v == 16'h003B, "R1 other address keeps control", v, 16'h003B);

        // R4, R9: continuous operation
        lat = 2; s0 = nstart;
        wr(4'd0, 16'h0045);
        repeat (60) @(negedge clk);
        check(nstart - s0 > 8, "R4 continuous repeats", nstart - s0, 9);
        rd(4'd1, v);
        check(((v >> 8) & 1) == 1, "R9 held in continuous", (v >> 8) & 1, 1);

        // R3, R10: abort with a conversion in flight, stale done ignored
        lat = 6;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (m_state == 2 && q_due.size() > 0 && q_due[0] > cyc + 2) break;
        end
        s0 = stale_cnt;
        wr(4'd0, 16'h0011);
        rd(4'd1, v);
        check(v == 0, "R3 abort clears flags", v, 0);
        wait_idle();
        check(stale_cnt > s0, "R10 stale done delivered", stale_cnt - s0, 1);
        rd(4'd1, v);
        check(v == 16'h01FF, "R10 new sequence intact", v, 16'h01FF);

        // R12: control write in the same cycle as an accepted done
        lat = 3;
        wr(4'd0, 16'h0005);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #1;
            if (conv_done && (int'(conv_done_tag) == (m_epoch % 4))) break;
        end
        rot_en = 0;
        bus_raddr = 4'd8;
        #1;
        r_before = int'(bus_rdata);
        bus_wr = 1'b1; bus_waddr = 4'd0; bus_wdata = 16'h0002;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_raddr = 4'd1;
        #4;
        check(bus_rdata == 16'h0000, "R12 write wins flags", int'(bus_rdata), 0);
        bus_raddr = 4'd8;
        #1;
        check(int'(bus_rdata) == r_before, "R12 slot untouched",
              int'(bus_rdata), r_before);
        rot_en = 1;
        wait_idle();
        repeat (10) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule